// File: doc/BRIEF.md
# Protected half-bridge control logic

This block is the digital core of a driver with three protected half bridges. A host writes a 16-bit command word over a chip-select-framed serial link. The word sets the high-side and low-side enable of each bridge, selects which fault shuts down a shorted switch, and can request a one-shot status reset. During the same frame the block shifts out a status word. That word holds per-switch state, latched open-load, short-circuit and undervoltage bits, and a live over-temperature pre-warning bit that is sent first.

Analog sensing is reduced to digital flags: open load, overcurrent and overtemperature for each switch, plus one pre-warning flag and one undervoltage flag. Each bridge has its own leg machine that turns the gates on and off. It inserts a dead gap whenever a bridge swaps sides, so the two switches never conduct together. A mode machine tracks the inhibit pin, an internal power-on delay and undervoltage.

The mode machine has three states. OFF is standby or power-on delay, RUN is normal drive and UV is supply lost. The transitions are: OFF to RUN after POR_CYC cycles with inhibit high; RUN to UV on the undervoltage flag; UV back to RUN when the flag clears; RUN or UV to OFF when inhibit goes low. Each leg has the states OFF, HS, LS and GAP. OFF goes to HS or LS on request. HS or LS goes to GAP when that side is no longer wanted. GAP goes to OFF after DT_CYC cycles. The serial machine has the states IDLE and SHIFT. It moves from IDLE to SHIFT on the falling edge of chip select and from SHIFT back to IDLE on the rising edge.

Top module: `hbridge_ctrl`

## Requirements
- R1: A frame of 16 bits, sent MSB first with data sampled on the rising edge of sclk, takes effect after csn rises. In the command word, bits [2:0] are the high-side enables of bridges 2..0 and bits [5:3] are the low-side enables. Bit 6 requests a status reset. Bit 7 selects the trip source: 0 for overtemperature, 1 for overcurrent.
- R2: A frame whose bit count is not a multiple of 16 leaves the command unchanged. For a frame of 32 bits, the last 16 bits apply.
- R3: The status word is captured when csn falls and shifted out MSB first. Bits [14:12] are high-side status and bits [11:9] are low-side status, each meaning commanded and not tripped. Bit 8 is open load, bit 7 is short circuit, bit 6 is undervoltage and bits [5:0] are 0.
- R4: Bit 15 of the status word is the live pre-warning flag. It appears on sdo while csn is low and before the first sclk falling edge, and it follows the flag without latching.
- R5: A bridge commanded to turn on both sides at once keeps both gates off.
- R6: When a bridge swaps from one side to the other, both gates stay off for DT_CYC+1 clock cycles.
- R7: The open-load bit sets only when a switch whose gate is on reports open load. It then holds.
- R8: The short-circuit bit sets when a switch whose gate is on reports overcurrent. It then holds.
- R9: With trip source 1, overcurrent on an on switch turns that switch off and holds it off. With trip source 0, overcurrent does not turn it off but overtemperature does. A tripped switch reads 0 in the status word.
- R10: A status reset is a single pulse. It clears the open-load, short-circuit and undervoltage bits and all trips, which re-enables the commanded switches. Latches can set again immediately afterwards, and frames without the request bit clear nothing.
- R11: Undervoltage turns all gates off and latches bit 6. When the supply recovers, the previous command is restored without a new frame.
- R12: While inhibit is low, out_hiz is 1, all gates are off, and the command and latches are cleared. After inhibit rises or reset ends, out_hiz stays 1 for POR_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inh_n | input | 1 | Inhibit; low selects standby |
| sclk | input | 1 | Serial clock, oversampled by clk |
| csn | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial command data |
| sdo | output | 1 | Serial status data, 0 outside a frame |
| tp_flag | input | 1 | Live over-temperature pre-warning |
| uv_flag | input | 1 | Supply undervoltage |
| ol_flag | input | 2*NB | Open load per switch: [NB-1:0] high sides, [2NB-1:NB] low sides |
| oc_flag | input | 2*NB | Overcurrent per switch, same order as ol_flag |
| ot_flag | input | 2*NB | Overtemperature per switch, same order as ol_flag |
| hs_en | output | NB | High-side gate enables |
| ls_en | output | NB | Low-side gate enables |
| out_hiz | output | 1 | All power outputs high impedance |

## Verification
Serial inputs pass through two sampling registers. A command therefore reaches the gates about four clk cycles after csn rises, and the bench waits at least eight before it compares. Fault flags act two cycles after they change, and trips and latches are read back in a later status frame. The dead gap is counted cycle by cycle at the gate pins and compared with DT_CYC+1. Undervoltage recovery and power-on checks wait longer than DT_CYC plus POR_CYC. The check after inhibit rises is made one cycle later, which is still inside the power-on window.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

    typedef enum logic [1:0] {
        MD_OFF,
        MD_RUN,
        MD_UV
    } mode_e;

    typedef enum logic [1:0] {
        LG_OFF,
        LG_HS,
        LG_LS,
        LG_GAP
    } leg_e;

    typedef enum logic {
        SP_IDLE,
        SP_SHIFT
    } sp_e;

endpackage

// File: rtl/hb_serial.sv
module hb_serial
    import hbridge_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         sclk,
    input  logic         csn,
    input  logic         sdi,
    input  logic         tp_live,
    input  logic [W-2:0] snap,
    output logic         sdo,
    output logic         cmd_stb,
    output logic [W-1:0] cmd_word
);
    localparam int CW = $clog2(W);

    logic sclk_q, sclk_qq, csn_q, csn_qq, sdi_q;
    logic sck_rise, sck_fall, cs_fall, cs_rise;
    sp_e  st, st_nx;
    logic [CW-1:0] cnt;
    logic          any_bit, first_ph;
    logic [W-1:0]  ish, osh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            csn_q   <= 1'b1;
            csn_qq  <= 1'b1;
            sdi_q   <= 1'b0;
        end else begin
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
            csn_q   <= csn;
            csn_qq  <= csn_q;
            sdi_q   <= sdi;
        end
    end

    assign sck_rise = sclk_q & ~sclk_qq;
    assign sck_fall = ~sclk_q & sclk_qq;
    assign cs_fall  = ~csn_q & csn_qq;
    assign cs_rise  = csn_q & ~csn_qq;

    always_comb begin
        st_nx = st;
        unique case (st)
            SP_IDLE:  if (cs_fall) st_nx = SP_SHIFT;
            SP_SHIFT: if (cs_rise) st_nx = SP_IDLE;
            default:  st_nx = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SP_IDLE;
        end else if (clr) begin
            st <= SP_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            any_bit  <= 1'b0;
            first_ph <= 1'b1;
            ish      <= '0;
            osh      <= '0;
        end else if (clr) begin
            cnt      <= '0;
            any_bit  <= 1'b0;
            first_ph <= 1'b1;
            ish      <= '0;
            osh      <= '0;
        end else if (st == SP_IDLE && cs_fall) begin
            cnt      <= '0;
            any_bit  <= 1'b0;
            first_ph <= 1'b1;
            osh      <= {1'b0, snap};
        end else if (st == SP_SHIFT) begin
            if (sck_rise) begin
                ish     <= {ish[W-2:0], sdi_q};
                cnt     <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
                any_bit <= 1'b1;
            end
            if (sck_fall && any_bit) begin
                first_ph <= 1'b0;
                osh      <= {osh[W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        sdo      = 1'b0;
        cmd_stb  = 1'b0;
        cmd_word = ish;
        if (st == SP_SHIFT) begin
            if (!csn_q) sdo = first_ph ? tp_live : osh[W-1];
            cmd_stb = cs_rise && any_bit && (cnt == '0);
        end
    end

    // R1
    stb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !clr) |=> (st == SP_IDLE));

endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hbridge_pkg::*;
#(
    parameter int DT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic want_hs,
    input  logic want_ls,
    output logic hs_on,
    output logic ls_on
);
    localparam int DW = $clog2(DT_CYC + 1);

    leg_e st, st_nx;
    logic [DW-1:0] gap_cnt;

    always_comb begin
        st_nx = st;
        unique case (st)
            LG_OFF: begin
                if (want_hs && !want_ls)      st_nx = LG_HS;
                else if (want_ls && !want_hs) st_nx = LG_LS;
            end
            LG_HS:   if (!want_hs) st_nx = LG_GAP;
            LG_LS:   if (!want_ls) st_nx = LG_GAP;
            LG_GAP:  if (gap_cnt == '0) st_nx = LG_OFF;
            default: st_nx = LG_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= LG_OFF;
            gap_cnt <= '0;
        end else if (clr) begin
            st      <= LG_OFF;
            gap_cnt <= '0;
        end else begin
            st <= st_nx;
            if (st != LG_GAP && st_nx == LG_GAP) gap_cnt <= DW'(DT_CYC - 1);
            else if (st == LG_GAP && gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
        end
    end

    always_comb begin
        hs_on = (st == LG_HS);
        ls_on = (st == LG_LS);
    end

    // dead-gap watch: consecutive both-off cycles and the side last on
    logic [DW-1:0] off_run;
    logic          last_hs, last_ls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run <= '0;
            last_hs <= 1'b0;
            last_ls <= 1'b0;
        end else begin
            if (hs_on || ls_on) off_run <= '0;
            else if (off_run != DW'(DT_CYC)) off_run <= off_run + 1'b1;
            if (hs_on) begin
                last_hs <= 1'b1;
                last_ls <= 1'b0;
            end else if (ls_on) begin
                last_hs <= 1'b0;
                last_ls <= 1'b1;
            end
        end
    end

    // R6
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ls_on && last_hs) || (hs_on && last_ls)) |-> (off_run == DW'(DT_CYC)));

endmodule

// File: rtl/hb_fault.sv
module hb_fault #(
    parameter int NS = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rst_pulse,
    input  logic          sel_oc,
    input  logic [NS-1:0] sw_on,
    input  logic [NS-1:0] ol_flag,
    input  logic [NS-1:0] oc_flag,
    input  logic [NS-1:0] ot_flag,
    input  logic          uv_flag,
    input  logic          uv_watch,
    output logic [NS-1:0] trip,
    output logic          ol_lat,
    output logic          scd_lat,
    output logic          psf_lat
);
    logic [NS-1:0] trip_src;

    assign trip_src = (sel_oc ? oc_flag : ot_flag) & sw_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip    <= '0;
            ol_lat  <= 1'b0;
            scd_lat <= 1'b0;
            psf_lat <= 1'b0;
        end else if (clr || rst_pulse) begin
            trip    <= '0;
            ol_lat  <= 1'b0;
            scd_lat <= 1'b0;
            psf_lat <= 1'b0;
        end else begin
            trip    <= trip | trip_src;
            ol_lat  <= ol_lat | (|(ol_flag & sw_on));
            scd_lat <= scd_lat | (|(oc_flag & sw_on));
            psf_lat <= psf_lat | (uv_flag & uv_watch);
        end
    end

    // R7
    ol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ol_lat) |-> $past(|(ol_flag & sw_on)));

    // R8
    scd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scd_lat) |-> $past(|(oc_flag & sw_on)));

    // R11
    psf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psf_lat) |-> $past(uv_flag));

    // R10
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(trip) & ~trip)) |-> $past(clr || rst_pulse));

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hbridge_pkg::*;
#(
    parameter int NB      = 3,
    parameter int W       = 16,
    parameter int DT_CYC  = 8,
    parameter int POR_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inh_n,
    input  logic            sclk,
    input  logic            csn,
    input  logic            sdi,
    output logic            sdo,
    input  logic            tp_flag,
    input  logic            uv_flag,
    input  logic [2*NB-1:0] ol_flag,
    input  logic [2*NB-1:0] oc_flag,
    input  logic [2*NB-1:0] ot_flag,
    output logic [NB-1:0]   hs_en,
    output logic [NB-1:0]   ls_en,
    output logic            out_hiz
);
    localparam int NS      = 2 * NB;
    localparam int SCR_BIT = 2 * NB;
    localparam int SEL_BIT = 2 * NB + 1;
    localparam int ST_HS   = W - 2;
    localparam int ST_LS   = W - 2 - NB;
    localparam int ST_OL   = W - 2 - 2 * NB;
    localparam int ST_SCD  = ST_OL - 1;
    localparam int ST_PSF  = ST_OL - 2;
    localparam int PW      = $clog2(POR_CYC + 1);

    mode_e mode, mode_nx;
    logic [PW-1:0] por_cnt;
    logic          clr, run, uv_watch;

    logic [NB-1:0] hs_cmd, ls_cmd;
    logic          sel_oc;
    logic          cmd_stb;
    logic [W-1:0]  cmd_word;
    logic [W-2:0]  snap;
    logic          rst_pulse;

    logic [NS-1:0] trip;
    logic          ol_lat, scd_lat, psf_lat;
    logic [NB-1:0] conflict, want_hs, want_ls;

    logic unused_hi;
    assign unused_hi = ^cmd_word[W-1:SEL_BIT+1];

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MD_OFF: if (inh_n && por_cnt == PW'(POR_CYC - 1)) mode_nx = MD_RUN;
            MD_RUN: begin
                if (!inh_n)        mode_nx = MD_OFF;
                else if (uv_flag)  mode_nx = MD_UV;
            end
            MD_UV: begin
                if (!inh_n)        mode_nx = MD_OFF;
                else if (!uv_flag) mode_nx = MD_RUN;
            end
            default: mode_nx = MD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= MD_OFF;
            por_cnt <= '0;
        end else begin
            mode <= mode_nx;
            if (mode != MD_OFF || !inh_n) por_cnt <= '0;
            else                          por_cnt <= por_cnt + 1'b1;
        end
    end

    always_comb begin
        clr      = (mode == MD_OFF);
        run      = (mode == MD_RUN);
        uv_watch = (mode != MD_OFF);
        out_hiz  = (mode == MD_OFF);
    end

    hb_serial #(.W(W)) u_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .sclk     (sclk),
        .csn      (csn),
        .sdi      (sdi),
        .tp_live  (tp_flag),
        .snap     (snap),
        .sdo      (sdo),
        .cmd_stb  (cmd_stb),
        .cmd_word (cmd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_cmd <= '0;
            ls_cmd <= '0;
            sel_oc <= 1'b0;
        end else if (clr) begin
            hs_cmd <= '0;
            ls_cmd <= '0;
            sel_oc <= 1'b0;
        end else if (cmd_stb) begin
            hs_cmd <= cmd_word[NB-1:0];
            ls_cmd <= cmd_word[2*NB-1:NB];
            sel_oc <= cmd_word[SEL_BIT];
        end
    end

    assign rst_pulse = cmd_stb & cmd_word[SCR_BIT];

    hb_fault #(.NS(NS)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .rst_pulse (rst_pulse),
        .sel_oc    (sel_oc),
        .sw_on     ({ls_en, hs_en}),
        .ol_flag   (ol_flag),
        .oc_flag   (oc_flag),
        .ot_flag   (ot_flag),
        .uv_flag   (uv_flag),
        .uv_watch  (uv_watch),
        .trip      (trip),
        .ol_lat    (ol_lat),
        .scd_lat   (scd_lat),
        .psf_lat   (psf_lat)
    );

    always_comb begin
        snap                 = '0;
        snap[ST_HS -: NB]    = hs_cmd & ~trip[NB-1:0];
        snap[ST_LS -: NB]    = ls_cmd & ~trip[NS-1:NB];
        snap[ST_OL]          = ol_lat;
        snap[ST_SCD]         = scd_lat;
        snap[ST_PSF]         = psf_lat;
    end

    always_comb begin
        conflict = hs_cmd & ls_cmd;
        want_hs  = hs_cmd & ~conflict & ~trip[NB-1:0] & {NB{run}};
        want_ls  = ls_cmd & ~conflict & ~trip[NS-1:NB] & {NB{run}};
    end

    for (genvar g = 0; g < NB; g++) begin : g_leg
        hb_leg #(.DT_CYC(DT_CYC)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .want_hs (want_hs[g]),
            .want_ls (want_ls[g]),
            .hs_on   (hs_en[g]),
            .ls_on   (ls_en[g])
        );
    end

    // R11
    uv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_UV && $past(mode == MD_UV)) |-> (hs_en == '0 && ls_en == '0));

    // R12
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_OFF && $past(mode == MD_OFF)) |-> (hs_en == '0 && ls_en == '0 && out_hiz));

    // R5
    both_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_cmd & ls_cmd & $past(hs_cmd & ls_cmd) & (hs_en | ls_en)) == '0));

    // R9
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(trip) & trip & {ls_en, hs_en}) == '0));

endmodule

// File: tb/hbridge_ctrl_test.sv
module hbridge_ctrl_test;
    localparam int NB  = 3;
    localparam int DT  = 8;
    localparam int POR = 4;

    logic clk = 1'b0;
    logic rst_n, inh_n, sclk, csn, sdi, tp_flag, uv_flag;
    logic [2*NB-1:0] ol_flag, oc_flag, ot_flag;
    logic sdo, out_hiz;
    logic [NB-1:0] hs_en, ls_en;

    int checks = 0;
    int errors = 0;
    logic [15:0] rx;

    always #2 clk = ~clk;

    hbridge_ctrl #(.NB(NB), .W(16), .DT_CYC(DT), .POR_CYC(POR)) uut (
        .clk(clk), .rst_n(rst_n), .inh_n(inh_n), .sclk(sclk), .csn(csn),
        .sdi(sdi), .sdo(sdo), .tp_flag(tp_flag), .uv_flag(uv_flag),
        .ol_flag(ol_flag), .oc_flag(oc_flag), .ot_flag(ot_flag),
        .hs_en(hs_en), .ls_en(ls_en), .out_hiz(out_hiz)
    );

    // dead-gap monitor on bridge 0
    int off_run = 0;
    int last_gap = -1;
    logic was_hs = 1'b0;
    always @(negedge clk) begin
        if (hs_en[0] || ls_en[0]) begin
            if (ls_en[0] && was_hs) last_gap = off_run;
            if (hs_en[0]) was_hs = 1'b1;
            else          was_hs = 1'b0;
            off_run = 0;
        end else begin
            off_run++;
        end
    end

    function automatic logic [15:0] cw(input logic [2:0] hs, input logic [2:0] ls,
                                       input logic scr, input logic sel);
        return {8'h00, sel, scr, ls, hs};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [31:0] tx, input int nb);
        rx = '0;
        csn = 1'b0;
        wait_clk(8);
        for (int i = 0; i < nb; i++) begin
            if (i < 16) rx = {rx[14:0], sdo};
            sdi = tx[nb-1-i];
            wait_clk(3);
            sclk = 1'b1;
            wait_clk(6);
            sclk = 1'b0;
            wait_clk(6);
        end
        csn = 1'b1;
        wait_clk(8);
    endtask

    task automatic send(input logic [15:0] c);
        xfer({16'h0000, c}, 16);
    endtask

    task automatic t_reset;
        check("R12 hiz right after reset", 32'(out_hiz), 32'd1);
        check("R12 gates off in reset", 32'({hs_en, ls_en}), 32'd0);
        wait_clk(12);
        check("R12 hiz released after power-on delay", 32'(out_hiz), 32'd0);
        send(cw(3'b000, 3'b000, 1'b0, 1'b0));
        check("R3 status word after reset", 32'(rx), 32'h0000);
    endtask

    task automatic t_drive;
        send(cw(3'b001, 3'b010, 1'b0, 1'b0));
        wait_clk(4);
        check("R1 high-side enables", 32'(hs_en), 32'b001);
        check("R1 low-side enables", 32'(ls_en), 32'b010);
        send(cw(3'b001, 3'b010, 1'b0, 1'b0));
        check("R3 status fields", 32'(rx), 32'h1400);
    endtask

    task automatic t_bad_frame;
        xfer({17'h0, 15'h0004}, 15);
        wait_clk(4);
        check("R2 15-bit frame ignored hs", 32'(hs_en), 32'b001);
        check("R2 15-bit frame ignored ls", 32'(ls_en), 32'b010);
        xfer({cw(3'b111, 3'b111, 1'b0, 1'b0), cw(3'b100, 3'b000, 1'b0, 1'b0)}, 32);
        wait_clk(20);
        check("R2 32-bit frame last word hs", 32'(hs_en), 32'b100);
        check("R2 32-bit frame last word ls", 32'(ls_en), 32'b000);
    endtask

    task automatic t_tp;
        tp_flag = 1'b1;
        csn = 1'b0;
        wait_clk(6);
        check("R4 pre-warning live high", 32'(sdo), 32'd1);
        tp_flag = 1'b0;
        wait_clk(1);
        check("R4 pre-warning live low", 32'(sdo), 32'd0);
        tp_flag = 1'b1;
        wait_clk(1);
        check("R4 pre-warning follows flag", 32'(sdo), 32'd1);
        csn = 1'b1;
        tp_flag = 1'b0;
        wait_clk(8);
        check("R2 empty frame ignored", 32'(hs_en), 32'b100);
    endtask

    task automatic t_conflict;
        send(cw(3'b100, 3'b100, 1'b0, 1'b0));
        wait_clk(20);
        check("R5 both sides commanded", 32'({hs_en[2], ls_en[2]}), 32'd0);
    endtask

    task automatic t_dead;
        send(cw(3'b001, 3'b000, 1'b0, 1'b0));
        wait_clk(20);
        check("R6 high side on before swap", 32'(hs_en[0]), 32'd1);
        last_gap = -1;
        send(cw(3'b000, 3'b001, 1'b0, 1'b0));
        wait_clk(20);
        check("R6 low side on after swap", 32'(ls_en[0]), 32'd1);
        check("R6 dead gap length", 32'(last_gap), 32'(DT + 1));
        send(cw(3'b000, 3'b000, 1'b0, 1'b0));
        wait_clk(20);
    endtask

    task automatic t_openload;
        send(cw(3'b001, 3'b000, 1'b0, 1'b0));
        wait_clk(4);
        ol_flag = 6'b000010;
        wait_clk(5);
        ol_flag = '0;
        send(cw(3'b001, 3'b000, 1'b0, 1'b0));
        check("R7 open load on off switch ignored", 32'(rx[8]), 32'd0);
        ol_flag = 6'b000001;
        wait_clk(5);
        ol_flag = '0;
        send(cw(3'b001, 3'b000, 1'b0, 1'b0));
        send(cw(3'b001, 3'b000, 1'b0, 1'b0));
        check("R7 open load latched", 32'(rx[8]), 32'd1);
        send(cw(3'b001, 3'b000, 1'b1, 1'b0));
        send(cw(3'b001, 3'b000, 1'b0, 1'b0));
        check("R10 reset clears open load", 32'(rx[8]), 32'd0);
        ol_flag = 6'b000001;
        wait_clk(5);
        ol_flag = '0;
        send(cw(3'b001, 3'b000, 1'b0, 1'b0));
        check("R10 latch sets again after reset pulse", 32'(rx[8]), 32'd1);
        send(cw(3'b001, 3'b000, 1'b1, 1'b0));
        wait_clk(20);
    endtask

    task automatic t_short;
        send(cw(3'b001, 3'b000, 1'b0, 1'b1));
        wait_clk(4);
        oc_flag = 6'b000001;
        wait_clk(5);
        oc_flag = '0;
        wait_clk(4);
        check("R9 overcurrent trip with source 1", 32'(hs_en), 32'b000);
        send(cw(3'b001, 3'b000, 1'b0, 1'b1));
        wait_clk(20);
        check("R9 tripped switch stays off", 32'(hs_en), 32'b000);
        check("R9 tripped switch status low", 32'(rx[14:12]), 32'b000);
        check("R8 short bit set", 32'(rx[7]), 32'd1);
        send(cw(3'b001, 3'b000, 1'b1, 1'b0));
        wait_clk(4);
        check("R10 reset re-enables switch", 32'(hs_en), 32'b001);
        oc_flag = 6'b000001;
        wait_clk(5);
        oc_flag = '0;
        check("R9 overcurrent no trip with source 0", 32'(hs_en), 32'b001);
        ot_flag = 6'b000001;
        wait_clk(5);
        ot_flag = '0;
        wait_clk(4);
        check("R9 overtemperature trip with source 0", 32'(hs_en), 32'b000);
        send(cw(3'b000, 3'b000, 1'b0, 1'b0));
        check("R8 short bit from overcurrent", 32'(rx[7]), 32'd1);
        send(cw(3'b000, 3'b000, 1'b1, 1'b0));
        send(cw(3'b000, 3'b000, 1'b0, 1'b0));
        check("R10 latches clear", 32'(rx[8:6]), 32'd0);
    endtask

    task automatic t_uv;
        send(cw(3'b001, 3'b000, 1'b0, 1'b0));
        wait_clk(4);
        uv_flag = 1'b1;
        wait_clk(6);
        check("R11 gates off on undervoltage", 32'({hs_en, ls_en}), 32'd0);
        uv_flag = 1'b0;
        wait_clk(20);
        check("R11 command restored", 32'(hs_en), 32'b001);
        send(cw(3'b001, 3'b000, 1'b0, 1'b0));
        check("R11 undervoltage latched", 32'(rx[6]), 32'd1);
        send(cw(3'b001, 3'b000, 1'b1, 1'b0));
        send(cw(3'b001, 3'b000, 1'b0, 1'b0));
        check("R10 undervoltage bit cleared", 32'(rx[6]), 32'd0);
    endtask

    task automatic t_inh;
        ol_flag = 6'b000001;
        wait_clk(4);
        ol_flag = '0;
        inh_n = 1'b0;
        wait_clk(3);
        check("R12 hiz in standby", 32'(out_hiz), 32'd1);
        check("R12 gates off in standby", 32'({hs_en, ls_en}), 32'd0);
        inh_n = 1'b1;
        wait_clk(1);
        check("R12 power-on delay holds hiz", 32'(out_hiz), 32'd1);
        wait_clk(12);
        check("R12 hiz released", 32'(out_hiz), 32'd0);
        check("R12 command cleared", 32'({hs_en, ls_en}), 32'd0);
        send(cw(3'b000, 3'b000, 1'b0, 1'b0));
        check("R12 latches cleared", 32'(rx), 32'h0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; inh_n = 1'b1; sclk = 1'b0; csn = 1'b1; sdi = 1'b0;
        tp_flag = 1'b0; uv_flag = 1'b0;
        ol_flag = '0; oc_flag = '0; ot_flag = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(1);
        t_reset();
        t_drive();
        t_bad_frame();
        t_tp();
        t_conflict();
        t_dead();
        t_openload();
        t_short();
        t_uv();
        t_inh();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule